// File: doc/BRIEF.md
# Raw Infrared Edge Interval Capture

This block measures the time between transitions of an already filtered infrared receiver input, so that software can decode any remote-control protocol from a list of durations. A programmable prescaler divides the core clock into ticks. An interval counter counts those ticks. When the input changes in a direction chosen by a two-bit select, the block latches the tick count and a flag that tells whether the segment that just ended was a pulse (input high) or a space (input low). It then restarts the counter from zero and raises a single-cycle interrupt.

The block captures only while it is enabled and its operating-mode field selects raw operation (value 2). Any other mode value, including 0 (hardware protocol decode, handled elsewhere), leaves it idle. A synchronous clear input resets the measurement state without a full chip reset. Long idle gaps saturate the counter rather than wrapping it. A busy flag marks an active burst: it is set on a rising input edge and drops once the input has stayed low long enough to saturate the counter.

Top module: `irEdgeCapture`

## Requirements
- R1: After each capture or clear, the interval counter advances by one every cfgBaseTime+1 clocks. A capture whose edge reaches the block k clocks after the previous capture or clear reports floor((k-1)/(cfgBaseTime+1)).
- R2: pulseOut is set, at the same edge as intervalOut, to the input level that held before the captured edge (1 = a high segment ended, 0 = a low segment ended).
- R3: cfgEdgeSel encodes 1 = both edges, 2 = falling edges only, 3 = rising edges only, 0 = decoder events only. In raw operation, 0 captures nothing.
- R4: Captures happen only while cfgEnable is 1 and cfgMode equals 2. Otherwise irqOut stays low, and intervalOut and pulseOut keep their values.
- R5: irqOut is high for exactly one clock per captured edge, in the cycle in which intervalOut and pulseOut first show the new values.
- R6: The interval counter saturates at 2^13-1 (8191) and does not wrap.
- R7: A one-clock cfgClear zeroes intervalOut, pulseOut, busyOut and the counters, and raises no interrupt.
- R8: busyOut rises after a rising input edge while the block is active. It falls when the counter is saturated with the input low, or when the block is cleared or made inactive.
- R9: After rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Filtered, clock-synchronous IR level, 1 = carrier present |
| cfgEnable | input | 1 | Capture enable |
| cfgClear | input | 1 | Synchronous clear of the measurement state |
| cfgMode | input | 4 | Operating mode, 2 = raw capture |
| cfgEdgeSel | input | 2 | Edge select for captures |
| cfgBaseTime | input | 12 | Tick length minus one, in clocks |
| intervalOut | output | 13 | Ticks between the last two captures |
| pulseOut | output | 1 | Level of the segment that ended at the last capture |
| busyOut | output | 1 | Burst in progress |
| irqOut | output | 1 | One-clock capture interrupt |

## Verification
The bench sweeps the tick length over several small values against every gap length from 1 to 12 clocks. This catches an off-by-one in the prescaler reload or a capture that reads the counter after its own increment, either of which would shift the reported count at the tick boundaries. Each edge-select value is exercised so that an edge of the unselected direction also spans the interval. A design that restarted the counter on ignored edges would report a count that is too short. A gap longer than the counter range checks that the count sticks at 8191 instead of wrapping to a small value, and that busy drops only after that point. The disabled state, the non-raw mode and the clear are each checked for a stray interrupt and for captured values that change.

// File: rtl/irCapPkg.sv
package irCapPkg;

  typedef enum logic [1:0] {
    SEL_DECODER = 2'd0,
    SEL_BOTH    = 2'd1,
    SEL_FALL    = 2'd2,
    SEL_RISE    = 2'd3
  } edgeSelT;

  localparam logic [3:0] MODE_RAW = 4'd2;

  // control to datapath strobes
  typedef struct packed {
    logic clear;     // synchronous clear of all measurement state
    logic hold;      // block inactive: counters parked at zero
    logic capture;   // latch interval and level, restart counters
    logic pulseLvl;  // level of the segment that just ended
  } capStrobeT;

endpackage

// File: rtl/irCapDatapath.sv
module irCapDatapath
  import irCapPkg::*;
#(
  parameter int BASE_W = 12,
  parameter int INTV_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BASE_W-1:0] baseTime,
  input  capStrobeT         strobe,
  output logic [INTV_W-1:0] intervalOut,
  output logic              pulseOut,
  output logic              cntSat
);

  localparam logic [INTV_W-1:0] CNT_MAX = {INTV_W{1'b1}};

  logic [BASE_W-1:0] presc;
  logic [INTV_W-1:0] count;

  assign cntSat = (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc       <= '0;
      count       <= '0;
      intervalOut <= '0;
      pulseOut    <= 1'b0;
    end else if (strobe.clear) begin
      presc       <= '0;
      count       <= '0;
      intervalOut <= '0;
      pulseOut    <= 1'b0;
    end else if (strobe.hold) begin
      presc <= '0;
      count <= '0;
    end else if (strobe.capture) begin
      intervalOut <= count;
      pulseOut    <= strobe.pulseLvl;
      presc       <= '0;
      count       <= '0;
    end else if (presc == baseTime) begin
      presc <= '0;
      if (!cntSat) count <= count + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  // R1: free-running counter moves by at most one per clock
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.hold && !strobe.capture) |=>
      (count == $past(count)) || (count == $past(count) + 1'b1));

  // R6: a saturated counter stays saturated until restarted
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntSat && !strobe.clear && !strobe.hold && !strobe.capture) |=> cntSat);

  // R7: clear empties the captured state
  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0) && (intervalOut == '0) && !pulseOut);

  // R4: inactive block keeps captured values
  p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hold && !strobe.clear) |=> $stable(intervalOut) && $stable(pulseOut));

endmodule

// File: rtl/irCapCtrl.sv
module irCapCtrl
  import irCapPkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              cfgEnable,
  input  logic              cfgClear,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [1:0]        cfgEdgeSel,
  input  logic              cntSat,
  output capStrobeT         strobe,
  output logic              irqOut,
  output logic              busyOut
);

  logic    prevLvl;
  logic    rise;
  logic    fall;
  logic    active;
  logic    hit;
  edgeSelT sel;

  assign sel    = edgeSelT'(cfgEdgeSel);
  assign rise   = irIn & ~prevLvl;
  assign fall   = ~irIn & prevLvl;
  assign active = cfgEnable && (cfgMode == MODE_W'(MODE_RAW));

  always_comb begin
    case (sel)
      SEL_BOTH: hit = rise | fall;
      SEL_FALL: hit = fall;
      SEL_RISE: hit = rise;
      default:  hit = 1'b0;
    endcase
  end

  assign strobe.clear    = cfgClear;
  assign strobe.hold     = !active;
  assign strobe.capture  = active && hit && !cfgClear;
  assign strobe.pulseLvl = prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= 1'b0;
      irqOut  <= 1'b0;
      busyOut <= 1'b0;
    end else begin
      prevLvl <= irIn;
      irqOut  <= strobe.capture;
      if (cfgClear || !active)  busyOut <= 1'b0;
      else if (rise)            busyOut <= 1'b1;
      else if (cntSat && !irIn) busyOut <= 1'b0;
    end
  end

  // R3: decoder-event select yields no raw capture
  p_sel_none_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sel == SEL_DECODER) |=> !irqOut);

  // R4: no interrupt while inactive
  p_inactive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !irqOut);

  // R7: clear never raises an interrupt
  p_clear_noirq_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgClear |=> !irqOut);

  // R8: rising edge while active marks the block busy
  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (active && rise && !cfgClear) |=> busyOut);

endmodule

// File: rtl/irEdgeCapture.sv
module irEdgeCapture
  import irCapPkg::*;
#(
  parameter int BASE_W = 12,
  parameter int INTV_W = 13,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irIn,
  input  logic              cfgEnable,
  input  logic              cfgClear,
  input  logic [MODE_W-1:0] cfgMode,
  input  logic [1:0]        cfgEdgeSel,
  input  logic [BASE_W-1:0] cfgBaseTime,
  output logic [INTV_W-1:0] intervalOut,
  output logic              pulseOut,
  output logic              busyOut,
  output logic              irqOut
);

  capStrobeT strobe;
  logic      cntSat;

  irCapCtrl #(.MODE_W(MODE_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .irIn       (irIn),
    .cfgEnable  (cfgEnable),
    .cfgClear   (cfgClear),
    .cfgMode    (cfgMode),
    .cfgEdgeSel (cfgEdgeSel),
    .cntSat     (cntSat),
    .strobe     (strobe),
    .irqOut     (irqOut),
    .busyOut    (busyOut)
  );

  irCapDatapath #(.BASE_W(BASE_W), .INTV_W(INTV_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .baseTime    (cfgBaseTime),
    .strobe      (strobe),
    .intervalOut (intervalOut),
    .pulseOut    (pulseOut),
    .cntSat      (cntSat)
  );

endmodule

// File: tb/tb_irEdgeCapture.sv
`timescale 1ns/100ps
module tb_irEdgeCapture;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irIn = 1'b0;
  logic        cfgEnable = 1'b0;
  logic        cfgClear = 1'b0;
  logic [3:0]  cfgMode = 4'd0;
  logic [1:0]  cfgEdgeSel = 2'd0;
  logic [11:0] cfgBaseTime = 12'd0;
  logic [12:0] intervalOut;
  logic        pulseOut;
  logic        busyOut;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irEdgeCapture dut (
    .clk(clk), .rstN(rstN), .irIn(irIn), .cfgEnable(cfgEnable),
    .cfgClear(cfgClear), .cfgMode(cfgMode), .cfgEdgeSel(cfgEdgeSel),
    .cfgBaseTime(cfgBaseTime), .intervalOut(intervalOut),
    .pulseOut(pulseOut), .busyOut(busyOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // clear at this negedge; the next edge may be driven k clocks later
  task automatic doClear(input int k);
    cfgClear = 1'b1;
    @(negedge clk);
    cfgClear = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  // drive a captured edge, check it, then check the interrupt drops (2 clocks)
  task automatic step(input logic v, input int expInt, input logic expP);
    irIn = v;
    @(negedge clk);
    chk("R5 irq on capture", int'(irqOut), 1);
    chk("R1 interval", int'(intervalOut), expInt);
    chk("R2 pulse flag", int'(pulseOut), int'(expP));
    @(negedge clk);
    chk("R5 irq one clock", int'(irqOut), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic lvl;
    int   held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 interval", int'(intervalOut), 0);
    chk("R9 pulse", int'(pulseOut), 0);
    chk("R9 busy", int'(busyOut), 0);
    chk("R9 irq", int'(irqOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    cfgEnable = 1'b1; cfgMode = 4'd2; cfgEdgeSel = 2'd1;
    lvl = 1'b0;

    // R1/R2 sweep: tick length vs gap length, both edges
    for (int b = 0; b < 4; b++) begin
      cfgBaseTime = 12'(b);
      for (int k = 1; k <= 12; k++) begin
        doClear(k);
        step(~lvl, (k - 1) / (b + 1), lvl);
        lvl = ~lvl;
      end
    end

    // R3 rising only, tick = 2 clocks; level now low
    cfgBaseTime = 12'd1;
    cfgEdgeSel = 2'd0; irIn = 1'b0; @(negedge clk);
    cfgEdgeSel = 2'd3;
    doClear(1);
    step(1'b1, 0, 1'b0);
    repeat (3) @(negedge clk);
    irIn = 1'b0;
    @(negedge clk);
    chk("R3 falling ignored in rise mode", int'(irqOut), 0);
    repeat (3) @(negedge clk);
    step(1'b1, 4, 1'b0);

    // R3 falling only; level now high
    cfgEdgeSel = 2'd2;
    doClear(3);
    step(1'b0, 1, 1'b1);
    repeat (3) @(negedge clk);
    irIn = 1'b1;
    @(negedge clk);
    chk("R3 rising ignored in fall mode", int'(irqOut), 0);
    repeat (3) @(negedge clk);
    step(1'b0, 4, 1'b1);

    // R3 select 0: no captures
    cfgEdgeSel = 2'd0;
    for (int i = 0; i < 4; i++) begin
      irIn = ~irIn;
      @(negedge clk);
      chk("R3 select 0 no irq", int'(irqOut), 0);
      chk("R3 select 0 interval held", int'(intervalOut), 4);
    end

    // R4 disabled and non-raw mode
    cfgEdgeSel = 2'd1;
    cfgEnable = 1'b0;
    for (int i = 0; i < 3; i++) begin
      irIn = ~irIn;
      @(negedge clk);
      chk("R4 disabled no irq", int'(irqOut), 0);
      chk("R4 disabled interval held", int'(intervalOut), 4);
    end
    cfgEnable = 1'b1; cfgMode = 4'd0;
    for (int i = 0; i < 3; i++) begin
      irIn = ~irIn;
      @(negedge clk);
      chk("R4 mode 0 no irq", int'(irqOut), 0);
      chk("R4 mode 0 pulse held", int'(pulseOut), 1);
    end
    cfgMode = 4'd2;

    // R6/R8 saturation and busy, tick = 1 clock
    cfgBaseTime = 12'd0;
    cfgEdgeSel = 2'd0; irIn = 1'b0; @(negedge clk);
    cfgEdgeSel = 2'd1;
    doClear(1);
    irIn = 1'b1;
    @(negedge clk);
    chk("R8 busy after rise", int'(busyOut), 1);
    @(negedge clk);
    repeat (3) @(negedge clk);
    irIn = 1'b0;
    @(negedge clk);
    held = int'(irqOut);
    chk("R5 irq on fall", held, 1);
    repeat (100) @(negedge clk);
    chk("R8 busy held in short gap", int'(busyOut), 1);
    repeat (8300) @(negedge clk);
    chk("R8 busy drops after saturation", int'(busyOut), 0);
    step(1'b1, 8191, 1'b0);
    chk("R6 saturated interval", int'(intervalOut), 8191);
    chk("R8 busy after new burst", int'(busyOut), 1);

    // R7 clear
    cfgClear = 1'b1;
    @(negedge clk);
    cfgClear = 1'b0;
    chk("R7 interval cleared", int'(intervalOut), 0);
    chk("R7 pulse cleared", int'(pulseOut), 0);
    chk("R7 busy cleared", int'(busyOut), 0);
    chk("R7 no irq", int'(irqOut), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule